// File: doc/BRIEF.md
# Reloading Down-Count Tick Timer

This block produces a regular time base for an operating system scheduler. A down-counter, `CNT_W` bits wide, steps once per tick. A tick is either every core clock cycle or each rising edge of an external tick input. The external input passes through a synchroniser and an edge detector first. The counter holds at zero for one tick and loads the reload value on the next tick, so one full cycle lasts reload+1 ticks. To get a period of N ticks, software writes N-1 to the reload register.

A wrap from one to zero sets a sticky wrap flag. Reading the control register clears the flag. While interrupts are enabled, the flag drives a level interrupt request.

Software uses four 32-bit registers on a simple single-cycle register bus:
- control/status at offset 0x0
- reload at offset 0x4
- current value at offset 0x8
- a read-only calibration constant at offset 0xC

Reads return data in the same cycle. Writes take effect at the clock edge. The usual start sequence writes the reload value, writes the current-value register, then writes 0x7 to control.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current-value registers read 0 and `irq` is low.
- R2: Control bit 0 enables counting, bit 1 enables the interrupt, and bit 2 selects the core clock (1) or the external tick input (0). These three bits read back as written. All other control bits ignore writes.
- R3: A write to the reload register keeps only the low `CNT_W` bits. The upper bits read as zero.
- R4: With the core clock selected and counting enabled, the counter drops by one each clock. At zero, the next tick loads the reload value, so the sequence repeats every reload+1 ticks.
- R5: Control bit 16 (the wrap flag) sets when a tick takes the counter from 1 to 0. Reading control returns the flag and then clears it. If a new wrap happens in the same cycle as the read, the flag stays set.
- R6: `irq` is high only while both the wrap flag and the interrupt enable are set. A wrap with the interrupt enable off leaves `irq` low.
- R7: Any write to the current-value register, whatever the data, sets the counter and the wrap flag to zero. The next tick then loads the reload value.
- R8: With the external source selected, the counter steps once for each rising edge of `ext_tick`. A steady level, whether high or low, does not count.
- R9: With counting disabled, the counter holds its value.
- R10: With a reload value of zero, the counter stays at zero and the wrap flag never sets.
- R11: The calibration register reads the `CAL_VALUE` parameter, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | External tick input, asynchronous to `clk` |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults:
- `CNT_W` = 24, which makes the reload truncation check meaningful on a real 32-bit write.
- `SYNC_STAGES` = 2, which keeps the latency from external edge to count short enough that a wait of a few cycles separates edges cleanly.
- A `CAL_VALUE` of 10000, which makes the calibration readback distinct from the reset value.

Small reload values (0, 3 and 4) bring the whole wrap cycle and the zero-reload stall within a handful of cycles, so each step of the period can be checked value by value.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // register byte offsets
  localparam int unsigned OFS_CTRL    = 0;
  localparam int unsigned OFS_RELOAD  = 4;
  localparam int unsigned OFS_CURRENT = 8;
  localparam int unsigned OFS_CALIB   = 12;

  // control/status bit positions
  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_IEN  = 1;
  localparam int unsigned BIT_CORE = 2;
  localparam int unsigned BIT_WRAP = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RELOAD,
    SEL_CURRENT,
    SEL_CALIB
  } reg_sel_e;
endpackage

// File: rtl/tick_src.sv
module tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic enable,
  input  logic src_core,
  output logic ext_rise,
  output logic tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign tick     = enable & (src_core | ext_rise);
endmodule

// File: rtl/tick_core.sv
module tick_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             flag_set
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - CNT_W'(1);
  endfunction

  function automatic logic is_wrap(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= next_count(cnt, reload);
  end

  assign flag_set = tick & ~clear & is_wrap(cnt);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int          CNT_W     = 24,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 4,
  parameter int unsigned CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag_set,
  output logic              enable,
  output logic              irq_en,
  output logic              src_core,
  output logic [CNT_W-1:0]  reload,
  output logic              flag,
  output logic              wr_cur,
  output logic              rd_ctrl
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_REL  = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(OFS_CURRENT);
  localparam logic [ADDR_W-1:0] A_CAL  = ADDR_W'(OFS_CALIB);
  localparam logic [DATA_W-1:0] CAL_WORD = DATA_W'(CAL_VALUE);

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      A_CTRL:  return SEL_CTRL;
      A_REL:   return SEL_RELOAD;
      A_CUR:   return SEL_CURRENT;
      A_CAL:   return SEL_CALIB;
      default: return SEL_NONE;
    endcase
  endfunction

  reg_sel_e sel;
  logic     wr_ctrl, wr_rel;
  logic     unused_wdata;

  assign sel     = decode(bus_addr);
  assign wr_ctrl = bus_sel & bus_we & (sel == SEL_CTRL);
  assign wr_rel  = bus_sel & bus_we & (sel == SEL_RELOAD);
  assign wr_cur  = bus_sel & bus_we & (sel == SEL_CURRENT);
  assign rd_ctrl = bus_sel & ~bus_we & (sel == SEL_CTRL);
  assign unused_wdata = &{1'b0, bus_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      irq_en   <= 1'b0;
      src_core <= 1'b0;
      reload   <= '0;
      flag     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        enable   <= bus_wdata[BIT_RUN];
        irq_en   <= bus_wdata[BIT_IEN];
        src_core <= bus_wdata[BIT_CORE];
      end
      if (wr_rel) reload <= bus_wdata[CNT_W-1:0];
      // a new wrap wins over the read-clear
      if (wr_cur)        flag <= 1'b0;
      else if (flag_set) flag <= 1'b1;
      else if (rd_ctrl)  flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CTRL: begin
        bus_rdata[BIT_RUN]  = enable;
        bus_rdata[BIT_IEN]  = irq_en;
        bus_rdata[BIT_CORE] = src_core;
        bus_rdata[BIT_WRAP] = flag;
      end
      SEL_RELOAD:  bus_rdata[CNT_W-1:0] = reload;
      SEL_CURRENT: bus_rdata[CNT_W-1:0] = cnt;
      SEL_CALIB:   bus_rdata = CAL_WORD;
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int          CNT_W       = 24,
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 4,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned CAL_VALUE   = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             enable, irq_en, src_core, flag, wr_cur, rd_ctrl;
  logic             tick, ext_rise, flag_set;
  logic [CNT_W-1:0] reload, cnt;

  tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_tick), .enable(enable),
    .src_core(src_core), .ext_rise(ext_rise), .tick(tick)
  );

  tick_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(wr_cur),
    .reload(reload), .cnt(cnt), .flag_set(flag_set)
  );

  tick_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CAL_VALUE(CAL_VALUE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .flag_set(flag_set), .enable(enable), .irq_en(irq_en),
    .src_core(src_core), .reload(reload), .flag(flag),
    .wr_cur(wr_cur), .rd_ctrl(rd_ctrl)
  );

  assign irq = flag & irq_en;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ext_rise,
  input logic             src_core,
  input logic             enable,
  input logic             irq_en,
  input logic             irq,
  input logic             flag,
  input logic             flag_set,
  input logic             wr_cur,
  input logic             rd_ctrl,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload
);
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cur && cnt > CNT_W'(1)) |=> cnt == $past(cnt) - CNT_W'(1));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cur && cnt == '0) |=> cnt == $past(reload));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cur && cnt == CNT_W'(1)) |=> flag);

  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !flag_set) |=> !flag);

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && irq_en));

  p_cur_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur |=> (cnt == '0 && !flag));

  p_ext_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !src_core) |-> ext_rise);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr_cur) |=> $stable(cnt));

  p_zero_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && reload == '0 && !wr_cur) |=> (cnt == '0 && !flag_set));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ext_rise(ext_rise),
  .src_core(src_core), .enable(enable), .irq_en(irq_en), .irq(irq),
  .flag(flag), .flag_set(flag_set), .wr_cur(wr_cur), .rd_ctrl(rd_ctrl),
  .cnt(cnt), .reload(reload)
);

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
  localparam int CNT_W = 24;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int unsigned CAL = 10000;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0, A_REL = 4'h4, A_CUR = 4'h8, A_CAL = 4'hC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_tick = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tick_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
               .SYNC_STAGES(2), .CAL_VALUE(CAL)) u_tick_timer (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    rd(A_REL, d);  check("R1 reload", d, 32'h0);
    rd(A_CUR, d);  check("R1 current", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    wr(A_REL, 32'hABCD_EF12);
    rd(A_REL, d); check("R3 reload truncation", d, 32'h00CD_EF12);
    wr(A_REL, 32'h0);
    wr(A_CUR, 32'h0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); check("R2 ctrl readback", d, 32'h0000_0007);
    wr(A_CTRL, 32'h0);
    rd(A_CAL, d); check("R11 calib value", d, CAL);
    wr(A_CAL, 32'h0);
    rd(A_CAL, d); check("R11 calib write ignored", d, CAL);
  endtask

  task automatic t_period;
    logic [31:0] d, h1, h2;
    int found = 0;
    wr(A_REL, 32'd4);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h7);
    for (int i = 0; i < 10 && found == 0; i++) begin
      rd(A_CUR, d);
      if (d == 32'd4) found = 1;
    end
    check("R4 reload reached", found, 1);
    rd(A_CUR, d); check("R4 step 3", d, 32'd3);
    rd(A_CUR, d); check("R4 step 2", d, 32'd2);
    rd(A_CUR, d); check("R4 step 1", d, 32'd1);
    rd(A_CUR, d); check("R4 step 0", d, 32'd0);
    rd(A_CUR, d); check("R4 reload after zero", d, 32'd4);
    check("R6 irq with flag and enable", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h6);
    rd(A_CTRL, d); check("R5 flag read", d, 32'h0001_0006);
    rd(A_CTRL, d); check("R5 flag cleared by read", d, 32'h0000_0006);
    check("R6 irq drops with flag", {31'b0, irq}, 32'h0);
    rd(A_CUR, h1);
    idle(10);
    rd(A_CUR, h2);
    check("R9 hold while disabled", h2, h1);
  endtask

  task automatic t_irq_off;
    logic [31:0] d;
    int seen = 0;
    wr(A_REL, 32'd2);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h5);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    check("R6 no irq without enable", seen, 0);
    wr(A_CTRL, 32'h4);
    rd(A_CTRL, d); check("R6 flag still sets", d, 32'h0001_0004);
  endtask

  task automatic t_cur_clear;
    logic [31:0] d;
    wr(A_REL, 32'd3);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h7);
    idle(10);
    wr(A_REL, 32'd100);
    wr(A_CUR, 32'h0000_DEAD);
    check("R7 irq cleared", {31'b0, irq}, 32'h0);
    rd(A_CTRL, d); check("R7 flag cleared", d, 32'h7);
    rd(A_CUR, d);  check("R7 next tick loads reload", d, 32'd100);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic pulse_ext(input int hi);
    @(negedge clk); ext_tick = 1'b1;
    repeat (hi) @(negedge clk);
    ext_tick = 1'b0;
    idle(6);
  endtask

  task automatic t_external;
    logic [31:0] d;
    wr(A_REL, 32'd5);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h3);
    idle(10);
    rd(A_CUR, d); check("R8 no edges no count", d, 32'd0);
    pulse_ext(3);
    rd(A_CUR, d); check("R8 first edge loads", d, 32'd5);
    pulse_ext(3);
    rd(A_CUR, d); check("R8 second edge steps", d, 32'd4);
    pulse_ext(20);
    rd(A_CUR, d); check("R8 long high counts once", d, 32'd3);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_zero_reload;
    logic [31:0] d;
    wr(A_REL, 32'd0);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h7);
    idle(20);
    rd(A_CUR, d);  check("R10 stays zero", d, 32'd0);
    check("R10 no irq", {31'b0, irq}, 32'h0);
    rd(A_CTRL, d); check("R10 no flag", d, 32'h7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fields();
    t_period();
    t_irq_off();
    t_cur_clear();
    t_external();
    t_zero_reload();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule